// File: doc/BRIEF.md
# Radix-4 Decimation-in-Frequency Butterfly

This block is the arithmetic core of a variable-length FFT engine. On every clock it takes four complex samples and three complex twiddle factors. It forms the four radix-4 sum and difference terms, and then rotates three of them by their twiddles. The zero-frequency term leaves without a multiply. An external sequencer feeds it one butterfly per cycle and supplies the twiddles. That sequencer also handles the memory, the address generation and the stage ordering.

Samples enter as signed 16-bit real/imaginary pairs with 15 fractional bits. Each pass through the block adds two integer bits, so the outputs are 18 bits wide and keep 15 fractional bits. Twiddles are signed 18-bit values with 17 fractional bits. After the complex multiply, the 17 extra fractional bits are dropped by truncation. Nothing saturates: any overflow wraps in two's complement. Two flags select the inverse transform. One negates the imaginary parts of the inputs, and the other negates the imaginary parts of the outputs. With both flags set, the forward datapath computes the inverse transform.

The pipeline has three register stages and no backpressure. A valid flag travels alongside the data.

Top module: `r4_butterfly`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a rising edge), `out_valid` is 0 and all eight output words are 0 until new data has moved through the pipeline.
- R2: `out_valid` equals the `in_valid` value captured three rising edges earlier: data sampled at edge t appears just after edge t+2.
- R3: Output 0 is a+b+c+d in 18-bit two's complement, with no twiddle applied.
- R4: With the input sums s1 = a−jb−c+jd, s2 = a−b+c−d and s3 = a+jb−c−jd, output k (k = 1..3) is the complex product sk·Wk. The real part is sr·wr−si·wi and the imaginary part is sr·wi+si·wr.
- R5: Each rotated product is shifted arithmetically right by 17 bits, which rounds toward minus infinity. The low 18 bits are kept. For example, a product of 131071 gives 0 and a product of −131071 gives −1.
- R6: When `conj_in` is 1, the imaginary parts of a, b, c and d are negated before the sums are formed.
- R7: When `conj_out` is 1, the imaginary part of all four outputs is negated, modulo 2^18, after truncation.
- R8: A new butterfly is accepted on every cycle, and back-to-back inputs each produce their own result.
- R9: Sums and products wrap modulo 2^18 and never saturate. For example, four imaginary inputs of −32768 with `conj_in` set give an output-0 imaginary part of −131072.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input butterfly is valid |
| conj_in | input | 1 | Negate input imaginary parts |
| conj_out | input | 1 | Negate output imaginary parts |
| a_re | input | 16 | Sample a, real |
| a_im | input | 16 | Sample a, imaginary |
| b_re | input | 16 | Sample b, real |
| b_im | input | 16 | Sample b, imaginary |
| c_re | input | 16 | Sample c, real |
| c_im | input | 16 | Sample c, imaginary |
| d_re | input | 16 | Sample d, real |
| d_im | input | 16 | Sample d, imaginary |
| w1_re | input | 18 | Twiddle 1, real, 17 fractional bits |
| w1_im | input | 18 | Twiddle 1, imaginary |
| w2_re | input | 18 | Twiddle 2, real |
| w2_im | input | 18 | Twiddle 2, imaginary |
| w3_re | input | 18 | Twiddle 3, real |
| w3_im | input | 18 | Twiddle 3, imaginary |
| out_valid | output | 1 | Output butterfly is valid |
| y0_re | output | 18 | Output 0, real |
| y0_im | output | 18 | Output 0, imaginary |
| y1_re | output | 18 | Output 1, real |
| y1_im | output | 18 | Output 1, imaginary |
| y2_re | output | 18 | Output 2, real |
| y2_im | output | 18 | Output 2, imaginary |
| y3_re | output | 18 | Output 3, real |
| y3_im | output | 18 | Output 3, imaginary |

## Verification
A wrong sign in one sum term, or a swapped twiddle lane, corrupts exactly one output pair three cycles after the offending input. Using distinct values on every lane therefore points to the faulty term. A conjugate flag that is misaligned with its data shows up as a sign flip on the imaginary outputs of the neighbouring butterfly, so back-to-back vectors with alternating flags are used to expose it. Truncation and wrap errors appear only at ±1 LSB and at full-scale codes, so directed vectors are placed at those exact values.

// File: rtl/r4_butterfly.sv
module r4_butterfly #(
  parameter int IN_W    = 16,
  parameter int TW_W    = 18,
  parameter int TW_FRAC = 17
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       conj_in,
  input  logic                       conj_out,
  input  logic signed [IN_W-1:0]     a_re,
  input  logic signed [IN_W-1:0]     a_im,
  input  logic signed [IN_W-1:0]     b_re,
  input  logic signed [IN_W-1:0]     b_im,
  input  logic signed [IN_W-1:0]     c_re,
  input  logic signed [IN_W-1:0]     c_im,
  input  logic signed [IN_W-1:0]     d_re,
  input  logic signed [IN_W-1:0]     d_im,
  input  logic signed [TW_W-1:0]     w1_re,
  input  logic signed [TW_W-1:0]     w1_im,
  input  logic signed [TW_W-1:0]     w2_re,
  input  logic signed [TW_W-1:0]     w2_im,
  input  logic signed [TW_W-1:0]     w3_re,
  input  logic signed [TW_W-1:0]     w3_im,
  output logic                       out_valid,
  output logic signed [IN_W+1:0]     y0_re,
  output logic signed [IN_W+1:0]     y0_im,
  output logic signed [IN_W+1:0]     y1_re,
  output logic signed [IN_W+1:0]     y1_im,
  output logic signed [IN_W+1:0]     y2_re,
  output logic signed [IN_W+1:0]     y2_im,
  output logic signed [IN_W+1:0]     y3_re,
  output logic signed [IN_W+1:0]     y3_im
);
  localparam int SW  = IN_W + 2;
  localparam int MW  = SW + TW_FRAC;
  localparam int LAT = 3;

  logic signed [SW-1:0] xr [4];
  logic signed [SW-1:0] xi [4];
  logic signed [SW-1:0] sr_d [4];
  logic signed [SW-1:0] si_d [4];
  logic signed [TW_W-1:0] wr_d [1:3];
  logic signed [TW_W-1:0] wi_d [1:3];

  assign xr[0] = SW'(a_re);
  assign xr[1] = SW'(b_re);
  assign xr[2] = SW'(c_re);
  assign xr[3] = SW'(d_re);
  assign xi[0] = conj_in ? -SW'(a_im) : SW'(a_im);
  assign xi[1] = conj_in ? -SW'(b_im) : SW'(b_im);
  assign xi[2] = conj_in ? -SW'(c_im) : SW'(c_im);
  assign xi[3] = conj_in ? -SW'(d_im) : SW'(d_im);

  assign wr_d[1] = w1_re;
  assign wi_d[1] = w1_im;
  assign wr_d[2] = w2_re;
  assign wi_d[2] = w2_im;
  assign wr_d[3] = w3_re;
  assign wi_d[3] = w3_im;

  always_comb begin
    sr_d[0] = xr[0] + xr[1] + xr[2] + xr[3];
    si_d[0] = xi[0] + xi[1] + xi[2] + xi[3];
    sr_d[1] = xr[0] + xi[1] - xr[2] - xi[3];
    si_d[1] = xi[0] - xr[1] - xi[2] + xr[3];
    sr_d[2] = xr[0] - xr[1] + xr[2] - xr[3];
    si_d[2] = xi[0] - xi[1] + xi[2] - xi[3];
    sr_d[3] = xr[0] - xi[1] - xr[2] + xi[3];
    si_d[3] = xi[0] + xr[1] - xi[2] - xr[3];
  end

  // stage 1: sums, twiddles, flags
  logic signed [SW-1:0]   s1r [4];
  logic signed [SW-1:0]   s1i [4];
  logic signed [TW_W-1:0] t1r [1:3];
  logic signed [TW_W-1:0] t1i [1:3];
  logic                   c1, c2;
  logic [LAT-1:0]         vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        s1r[i] <= '0;
        s1i[i] <= '0;
      end
      for (int i = 1; i <= 3; i++) begin
        t1r[i] <= '0;
        t1i[i] <= '0;
      end
      c1  <= 1'b0;
      c2  <= 1'b0;
      vld <= '0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        s1r[i] <= sr_d[i];
        s1i[i] <= si_d[i];
      end
      for (int i = 1; i <= 3; i++) begin
        t1r[i] <= wr_d[i];
        t1i[i] <= wi_d[i];
      end
      c1  <= conj_out;
      c2  <= c1;
      vld <= {vld[LAT-2:0], in_valid};
    end
  end

  // stage 2: products (wrapping width), stage 3: truncate and conjugate
  logic signed [SW-1:0] z2r, z2i;
  logic signed [SW-1:0] yr [4];
  logic signed [SW-1:0] yi [4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      z2r   <= '0;
      z2i   <= '0;
      yr[0] <= '0;
      yi[0] <= '0;
    end else begin
      z2r   <= s1r[0];
      z2i   <= s1i[0];
      yr[0] <= z2r;
      yi[0] <= c2 ? -z2i : z2i;
    end
  end

  for (genvar k = 1; k <= 3; k++) begin : g_rot
    logic signed [MW-1:0] p2r, p2i;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p2r   <= '0;
        p2i   <= '0;
        yr[k] <= '0;
        yi[k] <= '0;
      end else begin
        p2r   <= MW'(s1r[k]) * MW'(t1r[k]) - MW'(s1i[k]) * MW'(t1i[k]);
        p2i   <= MW'(s1r[k]) * MW'(t1i[k]) + MW'(s1i[k]) * MW'(t1r[k]);
        yr[k] <= SW'(p2r >>> TW_FRAC);
        yi[k] <= c2 ? -SW'(p2i >>> TW_FRAC) : SW'(p2i >>> TW_FRAC);
      end
    end
  end

  assign out_valid = vld[LAT-1];
  assign y0_re = yr[0];
  assign y0_im = yi[0];
  assign y1_re = yr[1];
  assign y1_im = yi[1];
  assign y2_re = yr[2];
  assign y2_im = yi[2];
  assign y3_re = yr[3];
  assign y3_im = yi[3];

  // checks
  logic [1:0] chk_age;
  logic signed [SW-1:0] chk_sum_re, chk_sum_im;
  assign chk_sum_re = SW'(a_re) + SW'(b_re) + SW'(c_re) + SW'(d_re);
  assign chk_sum_im = SW'(a_im) + SW'(b_im) + SW'(c_im) + SW'(d_im);

  always_ff @(posedge clk) begin
    if (!rst_n) chk_age <= '0;
    else if (chk_age != 2'd3) chk_age <= chk_age + 2'd1;
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age == 2'd0) |-> (!out_valid && y0_re == '0 && y0_im == '0 && y1_re == '0));

  a_r2_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  a_r3_dc_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age == 2'd3 && out_valid) |-> (y0_re == $past(chk_sum_re, 3)));

  a_r7_conj_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age == 2'd3 && out_valid && $past(conj_in == conj_out, 3))
      |-> (y0_im == $past(chk_sum_im, 3)));

  a_r5_zero_twiddle: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_age == 2'd3 && out_valid && $past(w1_re == '0 && w1_im == '0, 3))
      |-> (y1_re == '0 && y1_im == '0));
endmodule

// File: tb/r4_butterfly_tb.sv
module r4_butterfly_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic in_valid = 1'b0, conj_in = 1'b0, conj_out = 1'b0;
  logic signed [15:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic signed [15:0] c_re = '0, c_im = '0, d_re = '0, d_im = '0;
  logic signed [17:0] w1_re = '0, w1_im = '0, w2_re = '0, w2_im = '0, w3_re = '0, w3_im = '0;
  logic out_valid;
  logic signed [17:0] y0_re, y0_im, y1_re, y1_im, y2_re, y2_im, y3_re, y3_im;

  r4_butterfly dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .conj_in(conj_in), .conj_out(conj_out),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .c_re(c_re), .c_im(c_im), .d_re(d_re), .d_im(d_im),
    .w1_re(w1_re), .w1_im(w1_im), .w2_re(w2_re), .w2_im(w2_im), .w3_re(w3_re), .w3_im(w3_im),
    .out_valid(out_valid),
    .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im),
    .y2_re(y2_re), .y2_im(y2_im), .y3_re(y3_re), .y3_im(y3_im)
  );

  // fields: ar ai br bi cr ci dr di w1r w1i w2r w2i w3r w3i conj_in conj_out
  localparam int VEC [8][16] = '{
    '{0, 0, 0, 0, 0, 0, 0, 0, 5000, -7000, 1234, 99, -4321, 17, 0, 0},
    '{1000, -2000, 300, 400, -500, 600, 700, -800, 131071, 0, 0, -131072, 92682, -92682, 0, 0},
    '{1000, -2000, 300, 400, -500, 600, 700, -800, 131071, 0, 0, -131072, 92682, -92682, 1, 1},
    '{32767, 32767, 32767, -32768, -32768, 32767, -32768, -32768, 92682, 92682, -131072, 0, 131071, 131071, 0, 0},
    '{-12345, 6789, 2222, -3333, 4444, 5555, -6666, 7777, 65536, -113512, -65536, 113512, 121095, -50159, 1, 0},
    '{-12345, 6789, 2222, -3333, 4444, 5555, -6666, 7777, 65536, -113512, -65536, 113512, 121095, -50159, 0, 1},
    '{-1, -1, -1, 0, 0, -1, 1, 1, 131071, -1, -131071, 1, 1, 131071, 0, 0},
    '{16000, -16000, -16000, 16000, 8000, 8000, -8000, -8000, -92682, 92682, 131071, -131072, 0, 0, 1, 1}
  };

  int checks = 0, errors = 0, n_steps = 0;
  bit done = 1'b0;
  bit    hv  [512];
  int    hex [512][8];
  string htg [512];

  function automatic longint wrap(input longint v, input int bits);
    return (v <<< (64 - bits)) >>> (64 - bits);
  endfunction

  task automatic model(input int v[16], output int e[8]);
    longint ar, ai, br, bi, cr, ci, dr, di, pr, pi;
    longint sr[4], si[4];
    ar = v[0]; br = v[2]; cr = v[4]; dr = v[6];
    ai = v[14] ? -v[1] : v[1]; bi = v[14] ? -v[3] : v[3];
    ci = v[14] ? -v[5] : v[5]; di = v[14] ? -v[7] : v[7];
    sr[0] = wrap(ar + br + cr + dr, 18); si[0] = wrap(ai + bi + ci + di, 18);
    sr[1] = wrap(ar + bi - cr - di, 18); si[1] = wrap(ai - br - ci + dr, 18);
    sr[2] = wrap(ar - br + cr - dr, 18); si[2] = wrap(ai - bi + ci - di, 18);
    sr[3] = wrap(ar - bi - cr + di, 18); si[3] = wrap(ai + br - ci - dr, 18);
    e[0] = int'(sr[0]);
    e[1] = int'(v[15] ? wrap(-si[0], 18) : si[0]);
    for (int k = 1; k < 4; k++) begin
      pr = sr[k] * longint'(v[6 + 2*k]) - si[k] * longint'(v[7 + 2*k]);
      pi = sr[k] * longint'(v[7 + 2*k]) + si[k] * longint'(v[6 + 2*k]);
      pr = wrap(pr >>> 17, 18);
      pi = wrap(pi >>> 17, 18);
      e[2*k]   = int'(pr);
      e[2*k+1] = int'(v[15] ? wrap(-pi, 18) : pi);
    end
  endtask

  task automatic check_outputs();
    int idx;
    int got[8];
    if (n_steps < 3) return;
    idx = n_steps - 3;
    checks++;
    if (out_valid !== hv[idx]) begin
      errors++;
      $display("FAIL R2 step %0d out_valid actual %0b expected %0b", idx, out_valid, hv[idx]);
    end
    if (hv[idx]) begin
      got = '{int'(y0_re), int'(y0_im), int'(y1_re), int'(y1_im),
              int'(y2_re), int'(y2_im), int'(y3_re), int'(y3_im)};
      checks++;
      for (int j = 0; j < 8; j++)
        if (got[j] != hex[idx][j]) begin
          errors++;
          $display("FAIL %s step %0d word %0d actual %0d expected %0d", htg[idx], idx, j, got[j], hex[idx][j]);
          break;
        end
    end
  endtask

  task automatic step(input bit v, input int vec[16], input int ex[8], input string tag);
    @(negedge clk);
    check_outputs();
    in_valid = v;
    a_re = 16'(vec[0]); a_im = 16'(vec[1]); b_re = 16'(vec[2]); b_im = 16'(vec[3]);
    c_re = 16'(vec[4]); c_im = 16'(vec[5]); d_re = 16'(vec[6]); d_im = 16'(vec[7]);
    w1_re = 18'(vec[8]); w1_im = 18'(vec[9]); w2_re = 18'(vec[10]); w2_im = 18'(vec[11]);
    w3_re = 18'(vec[12]); w3_im = 18'(vec[13]);
    conj_in = vec[14][0]; conj_out = vec[15][0];
    hv[n_steps] = v;
    for (int j = 0; j < 8; j++) hex[n_steps][j] = ex[j];
    htg[n_steps] = tag;
    n_steps++;
  endtask

  task automatic step_model(input int vec[16], input string tag);
    int e[8];
    model(vec, e);
    step(1'b1, vec, e, tag);
  endtask

  function automatic int rnd(input int bits);
    int r;
    r = int'($urandom);
    return (r <<< (32 - bits)) >>> (32 - bits);
  endfunction

  initial begin
    int z16[16];
    int z8[8];
    int v[16];
    z16 = '{default: 0};
    z8  = '{default: 0};
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || y0_re != 0 || y0_im != 0 || y1_re != 0 || y2_im != 0 || y3_re != 0) begin
      errors++;
      $display("FAIL R1 reset state actual valid=%0b y0_re=%0d expected valid=0 all zero", out_valid, y0_re);
    end

    // R3 R4 R8: table walked back to back
    for (int i = 0; i < 8; i++) step_model(VEC[i], "R3_R4_R8 table");

    // R2: a bubble between valid vectors
    step(1'b0, z16, z8, "R2 bubble");
    // R3 R4: plain rotation by -1
    step(1'b1, '{16384, 8192, 0, 0, 0, 0, 0, 0, -131072, 0, -131072, 0, -131072, 0, 0, 0},
         '{16384, 8192, -16384, -8192, -16384, -8192, -16384, -8192}, "R3_R4 hand");
    // R7: output conjugate
    step(1'b1, '{16384, 8192, 0, 0, 0, 0, 0, 0, -131072, 0, -131072, 0, -131072, 0, 0, 1},
         '{16384, -8192, -16384, 8192, -16384, 8192, -16384, 8192}, "R7 hand");
    // R6: input conjugate
    step(1'b1, '{16384, 8192, 0, 0, 0, 0, 0, 0, -131072, 0, -131072, 0, -131072, 0, 1, 0},
         '{16384, -8192, -16384, 8192, -16384, 8192, -16384, 8192}, "R6 hand");
    // R5: truncation toward minus infinity
    step(1'b1, '{1, -1, 0, 0, 0, 0, 0, 0, 131071, 0, -131071, 0, 0, 131071, 0, 0},
         '{1, -1, 0, -1, -1, 0, 0, 0}, "R5 hand");
    // R9: wrap of conjugated full-scale imaginary parts
    step(1'b1, '{0, -32768, 0, -32768, 0, -32768, 0, -32768, 0, 0, 0, 0, 0, 0, 1, 0},
         '{0, -131072, 0, 0, 0, 0, 0, 0}, "R9 hand");
    // R3: most negative real sum fits exactly
    step(1'b1, '{-32768, 0, -32768, 0, -32768, 0, -32768, 0, 0, 0, 0, 0, 0, 0, 0, 0},
         '{-131072, 0, 0, 0, 0, 0, 0, 0}, "R3 hand");
    step(1'b0, z16, z8, "R2 idle");
    step(1'b0, z16, z8, "R2 idle");

    // R8 R6 R7: random back-to-back stream with random flags
    for (int i = 0; i < 60; i++) begin
      for (int j = 0; j < 8; j++) v[j] = rnd(16);
      for (int j = 8; j < 14; j++) v[j] = rnd(18);
      v[14] = int'($urandom & 1);
      v[15] = int'($urandom & 1);
      if (i % 13 == 5) step(1'b0, z16, z8, "R2 gap");
      else step_model(v, "R8_R6_R7 stream");
    end
    repeat (4) step(1'b0, z16, z8, "R2 flush");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule